// File: doc/BRIEF.md
# Indirect-Command CPU Bank Mapper

This block gives a CPU a two-step path to its banking state. A write into the lower command window stores a 4-bit command index. A write into the next window carries an 8-bit parameter and runs whichever command the index holds at that moment. Four commands load program-bank registers. The rest are passed out on a registered side port to the graphics mapper, the mirroring logic and the interrupt timer, none of which is part of this block.

From the bank registers and the current CPU address, the block builds a program-memory address and one chip select. The space from 0x6000 to 0xFFFF is split into five 8 KiB windows. The lowest window can show ROM or RAM, or it can leave the data bus undriven. The middle three windows show ROM banks chosen by software. The top window always shows the last ROM bank.

Top module: `cpu_bank_mapper`

## Requirements
- R1: A write (cpu_we_i=1) to any address in 0x8000–0x9FFF stores cpu_data_i[3:0] as the command index from the next cycle on, and data bits 7:4 are discarded.
- R2: A write to any address in 0xA000–0xBFFF runs the stored command with cpu_data_i as its parameter. Commands 9, 10 and 11 load the bank used at 0x8000, 0xA000 and 0xC000, each from data bits 5:0, and the new bank is visible on the address outputs from the next cycle.
- R3: Command 8 loads the 0x6000–0x7FFF window from one byte: bit 7 enables RAM, bit 6 selects RAM (1) over ROM (0), and bits 5:0 give the bank. With select 0 the window drives rom_cs_o. With select 1 and enable 1 it drives ram_cs_o. With select 1 and enable 0 it drives open_bus_o.
- R4: Addresses 0xE000–0xFFFF always assert rom_cs_o with bank 0x3F, the last 8 KiB bank of the default 512 KiB ROM.
- R5: One cycle after a parameter write whose index is 0–7 or 12–15, ext_wr_o pulses for one cycle with ext_idx_o equal to that index and ext_data_o equal to the parameter. Indexes 8–11 never raise ext_wr_o.
- R6: After reset the index is 0 and every bank register, enable bit and select bit is 0, so 0x6000 maps ROM bank 0.
- R7: Writes to 0xC000–0xFFFF or to addresses below 0x8000, and cycles with cpu_we_i=0, change no bank register and no index.
- R8: For addresses below 0x6000, rom_cs_o, ram_cs_o and open_bus_o are all 0.
- R9: At most one of rom_cs_o, ram_cs_o and open_bus_o is high. Whenever rom_cs_o or ram_cs_o is high, prg_addr_o equals {bank[5:0], cpu_addr_i[12:0]}. A parameter write leaves the index unchanged, so later parameter writes reuse it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | CPU bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | 16 | CPU address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_we_i | input | 1 | Write strobe, one cycle per write |
| prg_addr_o | output | 19 | Program memory address {bank, offset} |
| rom_cs_o | output | 1 | ROM chip select |
| ram_cs_o | output | 1 | RAM chip select |
| open_bus_o | output | 1 | Low window undriven |
| ext_wr_o | output | 1 | Forwarded command strobe |
| ext_idx_o | output | 4 | Forwarded command index |
| ext_data_o | output | 8 | Forwarded parameter |

## Verification
Register writes take effect at the clock edge where cpu_we_i is high. The address and select outputs are combinational from the registers and the address, so a new bank becomes visible in the cycle after the write. The bench therefore holds each write for one cycle, drops the strobe at the following falling edge, and then sets a probe address and samples one nanosecond later, in the middle of the low phase. The forwarded strobe is registered at the same edge, so it is checked at that first falling edge, before the next rising edge clears it.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
  localparam int unsigned SLOTS = 4;
  localparam int unsigned OFS_W = 13;

  typedef enum logic [2:0] {
    WIN_LOW   = 3'b011,
    WIN_IDX   = 3'b100,
    WIN_PAR   = 3'b101,
    WIN_HI    = 3'b110,
    WIN_FIXED = 3'b111
  } win_e;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_ROM,
    SRC_RAM,
    SRC_OPEN
  } src_e;

  // commands 8..11 belong to the program-bank side
  function automatic logic is_prg_cmd(input logic [3:0] idx);
    return idx[3:2] == 2'b10;
  endfunction
endpackage

// File: rtl/cbm_cmd_decode.sv
module cbm_cmd_decode
  import cbm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] win_i,
  input  logic       we_i,
  input  logic [7:0] data_i,
  output logic [3:0] idx_o,
  output logic       exec_o,
  output logic       ext_wr_o,
  output logic [3:0] ext_idx_o,
  output logic [7:0] ext_data_o
);
  logic       idx_hit, par_hit;
  logic [3:0] idx_q;
  logic       ext_wr_q;
  logic [3:0] ext_idx_q;
  logic [7:0] ext_data_q;

  assign idx_hit = we_i && (win_i == WIN_IDX);
  assign par_hit = we_i && (win_i == WIN_PAR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idx_q <= '0;
    else if (idx_hit) idx_q <= data_i[3:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_wr_q   <= 1'b0;
      ext_idx_q  <= '0;
      ext_data_q <= '0;
    end else begin
      ext_wr_q <= par_hit && !is_prg_cmd(idx_q);
      if (par_hit) begin
        ext_idx_q  <= idx_q;
        ext_data_q <= data_i;
      end
    end
  end

  assign idx_o      = idx_q;
  assign exec_o     = par_hit;
  assign ext_wr_o   = ext_wr_q;
  assign ext_idx_o  = ext_idx_q;
  assign ext_data_o = ext_data_q;

  p_idx_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_hit |=> idx_q == $past(data_i[3:0]));
  p_idx_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idx_hit |=> $stable(idx_q));
  p_ext_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_wr_q |-> $past(par_hit));
  p_ext_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_wr_q |-> !is_prg_cmd(ext_idx_q));
endmodule

// File: rtl/cbm_bank_regs.sv
module cbm_bank_regs
  import cbm_pkg::*;
#(
  parameter int unsigned BANK_W = 6
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          exec_i,
  input  logic [3:0]                    idx_i,
  input  logic [7:0]                    data_i,
  output logic [SLOTS-1:0][BANK_W-1:0]  bank_o,
  output logic                          ram_en_o,
  output logic                          ram_sel_o
);
  logic [SLOTS-1:0][BANK_W-1:0] bank_q;
  logic                         ram_en_q, ram_sel_q;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit;
    assign hit = exec_i && is_prg_cmd(idx_i) && (idx_i[1:0] == s[1:0]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bank_q[s] <= '0;
      else if (hit) bank_q[s] <= data_i[BANK_W-1:0];
    end
    if (s == 0) begin : g_mode
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          ram_en_q  <= 1'b0;
          ram_sel_q <= 1'b0;
        end else if (hit) begin
          ram_en_q  <= data_i[7];
          ram_sel_q <= data_i[6];
        end
      end
    end
  end

  assign bank_o    = bank_q;
  assign ram_en_o  = ram_en_q;
  assign ram_sel_o = ram_sel_q;

  p_bank_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> $stable(bank_q) && $stable(ram_en_q) && $stable(ram_sel_q));
  p_low_mode_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && idx_i == 4'd8) |=> ram_en_q == $past(data_i[7]) && ram_sel_q == $past(data_i[6]));
  p_ext_cmd_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && !is_prg_cmd(idx_i)) |=> $stable(bank_q));
endmodule

// File: rtl/cbm_window_xlate.sv
module cbm_window_xlate
  import cbm_pkg::*;
#(
  parameter int unsigned BANK_W = 6,
  localparam int unsigned AW    = BANK_W + OFS_W
) (
  input  logic [15:0]                  addr_i,
  input  logic [SLOTS-1:0][BANK_W-1:0] bank_i,
  input  logic                         ram_en_i,
  input  logic                         ram_sel_i,
  output logic [AW-1:0]                prg_addr_o,
  output src_e                         src_o
);
  localparam logic [BANK_W-1:0] LAST_BANK = '1;

  logic [BANK_W-1:0] bank_sel;

  always_comb begin
    bank_sel = '0;
    src_o    = SRC_NONE;
    unique case (addr_i[15:13])
      WIN_LOW: begin
        bank_sel = bank_i[0];
        if (!ram_sel_i)    src_o = SRC_ROM;
        else if (ram_en_i) src_o = SRC_RAM;
        else               src_o = SRC_OPEN;
      end
      WIN_IDX:   begin bank_sel = bank_i[1]; src_o = SRC_ROM; end
      WIN_PAR:   begin bank_sel = bank_i[2]; src_o = SRC_ROM; end
      WIN_HI:    begin bank_sel = bank_i[3]; src_o = SRC_ROM; end
      WIN_FIXED: begin bank_sel = LAST_BANK; src_o = SRC_ROM; end
      default: ;
    endcase
  end

  assign prg_addr_o = {bank_sel, addr_i[OFS_W-1:0]};
endmodule

// File: rtl/cpu_bank_mapper.sv
module cpu_bank_mapper
  import cbm_pkg::*;
#(
  parameter int unsigned ROM_KIB  = 512,
  localparam int unsigned ROM_AW  = $clog2(ROM_KIB * 1024),
  localparam int unsigned BANK_W  = ROM_AW - OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [15:0]       cpu_addr_i,
  input  logic [7:0]        cpu_data_i,
  input  logic              cpu_we_i,
  output logic [ROM_AW-1:0] prg_addr_o,
  output logic              rom_cs_o,
  output logic              ram_cs_o,
  output logic              open_bus_o,
  output logic              ext_wr_o,
  output logic [3:0]        ext_idx_o,
  output logic [7:0]        ext_data_o
);
  logic [3:0]                   idx;
  logic                         exec;
  logic [SLOTS-1:0][BANK_W-1:0] bank;
  logic                         ram_en, ram_sel;
  src_e                         src;

  cbm_cmd_decode u_dec (
    .clk_i, .rst_ni,
    .win_i      (cpu_addr_i[15:13]),
    .we_i       (cpu_we_i),
    .data_i     (cpu_data_i),
    .idx_o      (idx),
    .exec_o     (exec),
    .ext_wr_o   (ext_wr_o),
    .ext_idx_o  (ext_idx_o),
    .ext_data_o (ext_data_o)
  );

  cbm_bank_regs #(.BANK_W(BANK_W)) u_regs (
    .clk_i, .rst_ni,
    .exec_i    (exec),
    .idx_i     (idx),
    .data_i    (cpu_data_i),
    .bank_o    (bank),
    .ram_en_o  (ram_en),
    .ram_sel_o (ram_sel)
  );

  cbm_window_xlate #(.BANK_W(BANK_W)) u_xlate (
    .addr_i     (cpu_addr_i),
    .bank_i     (bank),
    .ram_en_i   (ram_en),
    .ram_sel_i  (ram_sel),
    .prg_addr_o (prg_addr_o),
    .src_o      (src)
  );

  assign rom_cs_o   = (src == SRC_ROM);
  assign ram_cs_o   = (src == SRC_RAM);
  assign open_bus_o = (src == SRC_OPEN);

  p_fixed_top_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i[15:13] == 3'b111) |-> rom_cs_o && (&prg_addr_o[ROM_AW-1:OFS_W]));
  p_low_none_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_addr_i < 16'h6000) |-> !(rom_cs_o || ram_cs_o || open_bus_o));
  p_one_sel_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({rom_cs_o, ram_cs_o, open_bus_o}) <= 1);
  p_offset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rom_cs_o || ram_cs_o) |-> prg_addr_o[OFS_W-1:0] == cpu_addr_i[OFS_W-1:0]);
endmodule

// File: tb/cpu_bank_mapper_tb.sv
module cpu_bank_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        we = 1'b0;
  logic [18:0] prg_addr;
  logic        rom_cs, ram_cs, open_bus, ext_wr;
  logic [3:0]  ext_idx;
  logic [7:0]  ext_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] m_idx;
  logic [5:0] m_bank [4];
  logic       m_en, m_sel;

  always #2 clk = ~clk;

  cpu_bank_mapper u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(addr), .cpu_data_i(data), .cpu_we_i(we),
    .prg_addr_o(prg_addr), .rom_cs_o(rom_cs), .ram_cs_o(ram_cs), .open_bus_o(open_bus),
    .ext_wr_o(ext_wr), .ext_idx_o(ext_idx), .ext_data_o(ext_data)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected select code: 0 none, 1 rom, 2 ram, 3 open
  function automatic logic [1:0] exp_src(input logic [15:0] a);
    if (a < 16'h6000) return 2'd0;
    if (a[15:13] == 3'b011) return !m_sel ? 2'd1 : (m_en ? 2'd2 : 2'd3);
    return 2'd1;
  endfunction

  function automatic logic [18:0] exp_addr(input logic [15:0] a);
    logic [5:0] b;
    case (a[15:13])
      3'b011:  b = m_bank[0];
      3'b100:  b = m_bank[1];
      3'b101:  b = m_bank[2];
      3'b110:  b = m_bank[3];
      default: b = 6'h3F;
    endcase
    return {b, a[12:0]};
  endfunction

  task automatic probe(input string req, input logic [15:0] a);
    logic [1:0] s;
    @(negedge clk);
    addr = a;
    #1;
    s = exp_src(a);
    chk(req, "selects", {29'd0, open_bus, ram_cs, rom_cs},
        {29'd0, s == 2'd3, s == 2'd2, s == 2'd1});
    if (s == 2'd1 || s == 2'd2) chk(req, "prg_addr", {13'd0, prg_addr}, {13'd0, exp_addr(a)});
  endtask

  task automatic do_write(input string req, input logic [15:0] a, input logic [7:0] d);
    logic       e_ext;
    logic [3:0] e_idx;
    @(negedge clk);
    addr = a; data = d; we = 1'b1;
    e_idx = m_idx;
    e_ext = (a[15:13] == 3'b101) && (m_idx[3:2] != 2'b10);
    if (a[15:13] == 3'b100) m_idx = d[3:0];
    if (a[15:13] == 3'b101 && m_idx[3:2] == 2'b10) begin
      m_bank[m_idx[1:0]] = d[5:0];
      if (m_idx[1:0] == 2'd0) begin m_en = d[7]; m_sel = d[6]; end
    end
    @(negedge clk);
    we = 1'b0;
    chk({req, "/R5"}, "ext_wr", {31'd0, ext_wr}, {31'd0, e_ext});
    if (e_ext) begin
      chk({req, "/R5"}, "ext_idx", {28'd0, ext_idx}, {28'd0, e_idx});
      chk({req, "/R5"}, "ext_data", {24'd0, ext_data}, {24'd0, d});
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed = 32'h5eed_0042;
    void'($urandom(seed));
    m_idx = '0; m_en = 0; m_sel = 0;
    foreach (m_bank[i]) m_bank[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R6 reset state
    probe("R6", 16'h6000);
    probe("R6", 16'h7ABC);
    probe("R4", 16'hE123);
    probe("R4", 16'hFFFF);
    probe("R8", 16'h5FFF);
    probe("R8", 16'h0000);
    do_write("R6", 16'hA000, 8'h55);   // index 0 after reset, forwarded

    // R1 upper data bits dropped, window edge address
    do_write("R1", 16'h9FFF, 8'hF9);
    do_write("R2", 16'hB000, 8'h05);
    probe("R2", 16'h8001);
    do_write("R9", 16'hA123, 8'h07);   // index persists
    probe("R9", 16'h9FFE);
    do_write("R1", 16'h8000, 8'h0A);
    do_write("R2", 16'hBFFF, 8'h3E);
    probe("R2", 16'hA555);
    do_write("R1", 16'h8400, 8'h6B);
    do_write("R2", 16'hA000, 8'hFF);
    probe("R2", 16'hDFFF);
    probe("R4", 16'hE000);

    // R3 low window modes
    do_write("R3", 16'h8000, 8'h08);
    do_write("R3", 16'hA000, 8'h0A);
    probe("R3", 16'h6010);
    do_write("R3", 16'hA000, 8'hC3);
    probe("R3", 16'h7FFF);
    do_write("R3", 16'hA000, 8'h43);
    probe("R3", 16'h6000);
    do_write("R3", 16'hA000, 8'h83);
    probe("R3", 16'h6001);

    // R7 ignored writes
    do_write("R7", 16'hC000, 8'h0B);
    do_write("R7", 16'hE000, 8'hFF);
    do_write("R7", 16'h7000, 8'h09);
    do_write("R7", 16'h2000, 8'h0C);
    probe("R7", 16'h6002);
    probe("R7", 16'hC100);
    do_write("R7", 16'hA000, 8'hC1);   // index still 8
    probe("R7", 16'h6003);

    // commands forwarded
    do_write("R5", 16'h8000, 8'h0C);
    do_write("R5", 16'hA000, 8'h02);
    do_write("R5", 16'h8000, 8'h0F);
    do_write("R5", 16'hA000, 8'h81);
    probe("R5", 16'hC000);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int unsigned r = $urandom % 5;
      logic [15:0] a;
      logic [7:0] d = 8'($urandom);
      case (r)
        0: a = {3'b100, 13'($urandom)};
        1, 2: a = {3'b101, 13'($urandom)};
        3: a = 16'($urandom);
        default: a = {3'b100, 13'($urandom)};
      endcase
      if (r == 0) d[3:2] = 2'b10;       // favour program commands
      do_write("R2", a, d);
      probe("R9", 16'($urandom));
      probe("R3", {3'b011, 13'($urandom)});
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule